// File: doc/BRIEF.md
# Endurance Remapper with Row Rotation and Segment Swapping

This block sits between a requester and a memory whose cells wear out with repeated writes. It spreads wear at two scales at once. Inside a row, every written word is rotated by a global shift offset before it is stored, so a bit that is hot in the requester's view lands on a different cell as the offset moves. The offset that was in force is stored in the same memory word, next to the data. A read rotates the data back using that stored offset, so older rows stay correct after the offset has moved on.

Across the memory, the block keeps a saturating write counter for each physical segment and a table that maps each logical segment to a physical one. After every P writes, it looks for the most-written and the least-written physical segment. If they differ enough, it exchanges their contents row by row through a one-word holding register and then exchanges their map entries. While this runs, requests are held off. The counters are halved after each exchange, so the history fades.

The requester issues one request per cycle under a valid/ready handshake. The memory port is a simple synchronous single-port interface with one cycle of read latency.

Top module: `wl_remap`

## Requirements
- R1: An accepted write drives one memory write in the same cycle to address phys*ROWS+row, where phys is the mapped physical segment. The stored word holds the current shift offset in its upper OFF_W bits and, in its lower DATA_W bits, the write data rotated left by that offset (bit i moves to bit (i+offset) mod DATA_W).
- R2: An accepted read drives a memory read in the same cycle to the mapped address. rsp_valid is high in the following cycle, and rsp_rdata equals the returned data rotated right by the offset stored in that word.
- R3: Each physical segment has a saturating write counter that counts accepted writes to it and stays at its maximum value instead of wrapping. The swap candidates are the segment with the highest count and the segment with the lowest count, with the lowest index winning a tie in each case.
- R4: After reset the map is the identity. Every request is steered to the physical segment that the current map gives for its logical segment.
- R5: The shift offset starts at 0 after reset and advances by one after every K_WRITES accepted writes, wrapping from DATA_W-1 to 0. A write always uses the offset in force before its own count is taken.
- R6: After every P_WRITES-th write, req_ready is low for one selection cycle. If a swap is chosen, req_ready then stays low for 4*ROWS more cycles. For rows 0 upward, the block reads the hot segment's row, reads the cold segment's row, writes the cold data into the hot row, and writes the held hot data into the cold row. The two map entries are then exchanged, so every logical row still reads back its last written value. No response is issued during these cycles.
- R7: The swap is skipped, with req_ready low for exactly one cycle and the map unchanged, when the hot and cold segments are the same segment or their counts differ by less than THRESH.
- R8: When a swap completes, every counter is shifted right by one bit, and later selections use the halved values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (low while selecting or swapping) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | SEG_W | Logical segment number |
| req_row | input | ROW_W | Row within the segment |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | DATA_W | Read data, rotated back |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | SEG_W+ROW_W | Physical address {segment,row} |
| mem_wdata | output | OFF_W+DATA_W | Stored word {offset,rotated data} |
| mem_rdata | input | OFF_W+DATA_W | Word read from memory, one cycle after the read |

## Verification
The bench runs a small configuration with 4 segments of 4 rows, 16-bit data and 4-bit counters, and walks the write stream through four distinct patterns. A uniform fill makes all counters equal, so the hot and cold candidates coincide and the swap must be skipped. A stream heavily skewed to one segment must trigger an exchange of a specific pair. A balanced stream leaves counts within the threshold, which only holds if the counters were halved. A run of 16 writes to a single segment separates a saturating counter from a wrapping one, because the wrapped count would suppress the swap. Every write is checked at the memory port for address, rotation and stored offset across an offset wrap, and a full read-back after each pattern confirms that the copies and the map update kept every logical row intact.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // Sequencer states: idle service, hot/cold selection, four-step row copy
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_RD_A,
        ST_RD_B,
        ST_WR_A,
        ST_WR_B
    } wl_state_e;

    // Default geometry
    localparam int WL_SEGS   = 8;
    localparam int WL_ROWS   = 16;
    localparam int WL_DATA_W = 32;
    localparam int WL_CNT_W  = 16;

    // Offset advance: wraps modulo the row width
    function automatic int unsigned wl_next_off(int unsigned cur, int unsigned width);
        return (cur + 1 >= width) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/wl_rotator.sv
module wl_rotator #(
    parameter int W     = 32,
    parameter int OFF_W = 5,
    parameter bit LEFT  = 1'b1
) (
    input  logic [W-1:0]     din,
    input  logic [OFF_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [2*W-1:0] dbl;

    generate
        if (LEFT) begin : g_left
            assign dbl  = {din, din} << amt;
            assign dout = dbl[2*W-1:W];
        end else begin : g_right
            assign dbl  = {din, din} >> amt;
            assign dout = dbl[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/wl_wear_table.sv
module wl_wear_table #(
    parameter int SEGS  = 8,
    parameter int CNT_W = 16,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [SEG_W-1:0] inc_seg,
    input  logic             halve,
    output logic [SEG_W-1:0] hot_seg,
    output logic [SEG_W-1:0] cold_seg,
    output logic [CNT_W-1:0] hot_cnt,
    output logic [CNT_W-1:0] cold_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [SEGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SEGS; i++) cnt_q[i] <= '0;
        end else if (halve) begin
            for (int i = 0; i < SEGS; i++) cnt_q[i] <= cnt_q[i] >> 1;
        end else if (inc_en && cnt_q[inc_seg] != CNT_MAX) begin
            cnt_q[inc_seg] <= cnt_q[inc_seg] + 1'b1;
        end
    end

    // Linear scan, first index wins ties
    always_comb begin
        hot_seg  = '0;
        cold_seg = '0;
        hot_cnt  = cnt_q[0];
        cold_cnt = cnt_q[0];
        for (int i = 1; i < SEGS; i++) begin
            if (cnt_q[i] > hot_cnt) begin
                hot_cnt = cnt_q[i];
                hot_seg = SEG_W'(i);
            end
            if (cnt_q[i] < cold_cnt) begin
                cold_cnt = cnt_q[i];
                cold_seg = SEG_W'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < SEGS; g++) begin : g_sat_chk
            p_cnt_sat_r3: assert property (@(posedge clk) disable iff (rst)
                (cnt_q[g] == CNT_MAX && inc_en && inc_seg == SEG_W'(g) && !halve)
                |=> (cnt_q[g] == CNT_MAX));
        end
    endgenerate

    p_hot_ge_cold_r3: assert property (@(posedge clk) disable iff (rst)
        hot_cnt >= cold_cnt);
endmodule

// File: rtl/wl_seg_map.sv
module wl_seg_map #(
    parameter int SEGS  = 8,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEG_W-1:0] lookup_log,
    output logic [SEG_W-1:0] lookup_phys,
    input  logic             swap_en,
    input  logic [SEG_W-1:0] swap_a,
    input  logic [SEG_W-1:0] swap_b
);
    logic [SEG_W-1:0] map_q [SEGS];
    logic [SEGS-1:0]  used;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SEGS; i++) map_q[i] <= SEG_W'(i);
        end else if (swap_en) begin
            for (int i = 0; i < SEGS; i++) begin
                if (map_q[i] == swap_a)      map_q[i] <= swap_b;
                else if (map_q[i] == swap_b) map_q[i] <= swap_a;
            end
        end
    end

    assign lookup_phys = map_q[lookup_log];

    always_comb begin
        used = '0;
        for (int i = 0; i < SEGS; i++) used[map_q[i]] = 1'b1;
    end

    // The table must stay a permutation
    p_map_perm_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(used) == SEGS);
endmodule

// File: rtl/wl_remap.sv
module wl_remap
    import wl_pkg::*;
#(
    parameter int SEGS     = WL_SEGS,
    parameter int ROWS     = WL_ROWS,
    parameter int DATA_W   = WL_DATA_W,
    parameter int CNT_W    = WL_CNT_W,
    parameter int K_WRITES = 4,
    parameter int P_WRITES = 64,
    parameter int THRESH   = 4,
    localparam int SEG_W   = $clog2(SEGS),
    localparam int ROW_W   = $clog2(ROWS),
    localparam int OFF_W   = $clog2(DATA_W),
    localparam int ADDR_W  = SEG_W + ROW_W,
    localparam int MEM_W   = OFF_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]  mem_wdata,
    input  logic [MEM_W-1:0]  mem_rdata
);
    localparam int KC_W = $clog2(K_WRITES + 1);
    localparam int PC_W = $clog2(P_WRITES + 1);

    wl_state_e         state_q;
    logic [OFF_W-1:0]  off_q;
    logic [KC_W-1:0]   kcnt_q;
    logic [PC_W-1:0]   pcnt_q;
    logic [ROW_W-1:0]  row_q;
    logic [SEG_W-1:0]  hot_q, cold_q;
    logic [MEM_W-1:0]  buf_q;
    logic              rd_pend_q;

    logic              accept, wr_acc, do_swap, swap_done;
    logic [SEG_W-1:0]  phys_lu, hot_seg, cold_seg;
    logic [CNT_W-1:0]  hot_cnt, cold_cnt;
    logic [DATA_W-1:0] rot_w;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_acc    = accept && req_write;
    assign do_swap   = (hot_seg != cold_seg) && ((hot_cnt - cold_cnt) >= CNT_W'(THRESH));
    assign swap_done = (state_q == ST_WR_B) && (row_q == ROW_W'(ROWS - 1));

    wl_seg_map #(.SEGS(SEGS), .SEG_W(SEG_W)) u_map (
        .clk        (clk),
        .rst        (rst),
        .lookup_log (req_seg),
        .lookup_phys(phys_lu),
        .swap_en    (swap_done),
        .swap_a     (hot_q),
        .swap_b     (cold_q)
    );

    wl_wear_table #(.SEGS(SEGS), .CNT_W(CNT_W), .SEG_W(SEG_W)) u_wear (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (wr_acc),
        .inc_seg (phys_lu),
        .halve   (swap_done),
        .hot_seg (hot_seg),
        .cold_seg(cold_seg),
        .hot_cnt (hot_cnt),
        .cold_cnt(cold_cnt)
    );

    wl_rotator #(.W(DATA_W), .OFF_W(OFF_W), .LEFT(1'b1)) u_rot_wr (
        .din (req_wdata),
        .amt (off_q),
        .dout(rot_w)
    );

    wl_rotator #(.W(DATA_W), .OFF_W(OFF_W), .LEFT(1'b0)) u_rot_rd (
        .din (mem_rdata[DATA_W-1:0]),
        .amt (mem_rdata[MEM_W-1:DATA_W]),
        .dout(rsp_rdata)
    );

    assign rsp_valid = rd_pend_q;

    // Memory port steering
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {phys_lu, req_row};
        mem_wdata = {off_q, rot_w};
        unique case (state_q)
            ST_IDLE: begin
                mem_en = req_valid;
                mem_we = req_write;
            end
            ST_RD_A: begin
                mem_en   = 1'b1;
                mem_addr = {hot_q, row_q};
            end
            ST_RD_B: begin
                mem_en   = 1'b1;
                mem_addr = {cold_q, row_q};
            end
            ST_WR_A: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {hot_q, row_q};
                mem_wdata = mem_rdata;
            end
            ST_WR_B: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cold_q, row_q};
                mem_wdata = buf_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            off_q     <= '0;
            kcnt_q    <= '0;
            pcnt_q    <= '0;
            row_q     <= '0;
            hot_q     <= '0;
            cold_q    <= '0;
            buf_q     <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= accept && !req_write;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_acc) begin
                        if (kcnt_q == KC_W'(K_WRITES - 1)) begin
                            kcnt_q <= '0;
                            off_q  <= OFF_W'(wl_next_off(int'(off_q), DATA_W));
                        end else begin
                            kcnt_q <= kcnt_q + 1'b1;
                        end
                        if (pcnt_q == PC_W'(P_WRITES - 1)) begin
                            pcnt_q  <= '0;
                            state_q <= ST_SEL;
                        end else begin
                            pcnt_q <= pcnt_q + 1'b1;
                        end
                    end
                end
                ST_SEL: begin
                    if (do_swap) begin
                        hot_q   <= hot_seg;
                        cold_q  <= cold_seg;
                        row_q   <= '0;
                        state_q <= ST_RD_A;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_RD_A: state_q <= ST_RD_B;
                ST_RD_B: begin
                    buf_q   <= mem_rdata;
                    state_q <= ST_WR_A;
                end
                ST_WR_A: state_q <= ST_WR_B;
                ST_WR_B: begin
                    if (row_q == ROW_W'(ROWS - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        row_q   <= row_q + 1'b1;
                        state_q <= ST_RD_A;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A response only ever follows a requester read issued in service mode
    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_en && !mem_we && req_ready));

    // No responses while selecting or copying
    p_no_rsp_in_swap_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !rsp_valid);

    // The second copy write targets a different segment than the first
    p_copy_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_B) |->
        (mem_addr[ADDR_W-1:ROW_W] != $past(mem_addr[ADDR_W-1:ROW_W])));

    // Offset moves only by a single wrapped step
    p_offset_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(off_q) |->
        (off_q == OFF_W'(wl_next_off(int'($past(off_q)), DATA_W))));
endmodule

// File: tb/wl_remap_bench.sv
module wl_remap_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEGS = 4, ROWS = 4, DATA_W = 16, CNT_W = 4;
    localparam int K_WR = 3, P_WR = 16, THR = 3;
    localparam int SEG_W = 2, ROW_W = 2, OFF_W = 4;
    localparam int ADDR_W = SEG_W + ROW_W, MEM_W = OFF_W + DATA_W;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_en, mem_we;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [MEM_W-1:0] mem_wdata, mem_rdata;

    logic [MEM_W-1:0] mem [SEGS*ROWS];

    int checks = 0, failures = 0, wr_total = 0;
    int exp_map [SEGS];
    int exp_cnt [SEGS];
    logic [DATA_W-1:0] shadow [SEGS][ROWS];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    wl_remap #(.SEGS(SEGS), .ROWS(ROWS), .DATA_W(DATA_W), .CNT_W(CNT_W),
               .K_WRITES(K_WR), .P_WRITES(P_WR), .THRESH(THR)) u_wl_remap (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_seg(req_seg), .req_row(req_row),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] rotl(logic [DATA_W-1:0] d, int s);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[(i + s) % DATA_W] = d[i];
        return r;
    endfunction

    task automatic handle_select(string tag);
        int hot = 0, cold = 0, n = 0, exp_stall;
        bit swap;
        logic [ADDR_W-1:0] first_addr = '0;
        for (int i = 1; i < SEGS; i++) begin
            if (exp_cnt[i] > exp_cnt[hot])  hot = i;
            if (exp_cnt[i] < exp_cnt[cold]) cold = i;
        end
        swap = (hot != cold) && (exp_cnt[hot] - exp_cnt[cold] >= THR);
        exp_stall = swap ? 1 + 4*ROWS : 1;
        while (!req_ready && n < 1000) begin
            if (n == 1) first_addr = mem_addr;
            check(!rsp_valid, "R6", "response during stall", 32'(rsp_valid), 0);
            n++;
            @(negedge clk);
        end
        if (swap) begin
            check(n == exp_stall, {"R6 ", tag}, "swap stall cycles", n, exp_stall);
            check(int'(first_addr) == hot*ROWS, {"R3 ", tag}, "first copy address", 32'(first_addr), hot*ROWS);
            for (int l = 0; l < SEGS; l++) begin
                if (exp_map[l] == hot)       exp_map[l] = cold;
                else if (exp_map[l] == cold) exp_map[l] = hot;
            end
            for (int p = 0; p < SEGS; p++) exp_cnt[p] = exp_cnt[p] / 2;
        end else begin
            check(n == 1, {"R7 ", tag}, "skip stall cycles", n, 1);
        end
    endtask

    task automatic do_write(int l, int r, logic [DATA_W-1:0] d, string tag);
        int off, p;
        off = (wr_total / K_WR) % DATA_W;
        p = exp_map[l];
        req_valid = 1'b1; req_write = 1'b1;
        req_seg = SEG_W'(l); req_row = ROW_W'(r); req_wdata = d;
        #1;
        check(req_ready && mem_en && mem_we && int'(mem_addr) == p*ROWS + r, "R1 R4",
              "write address", 32'(mem_addr), p*ROWS + r);
        check(mem_wdata[DATA_W-1:0] == rotl(d, off), "R1", "rotated data",
              32'(mem_wdata[DATA_W-1:0]), 32'(rotl(d, off)));
        check(int'(mem_wdata[MEM_W-1:DATA_W]) == off, "R5", "stored offset",
              32'(mem_wdata[MEM_W-1:DATA_W]), off);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        shadow[l][r] = d;
        wr_total++;
        if (exp_cnt[p] < CMAX) exp_cnt[p]++;
        if (wr_total % P_WR == 0) handle_select(tag);
    endtask

    task automatic do_read(int l, int r);
        req_valid = 1'b1; req_write = 1'b0;
        req_seg = SEG_W'(l); req_row = ROW_W'(r);
        #1;
        check(req_ready && mem_en && !mem_we && int'(mem_addr) == exp_map[l]*ROWS + r, "R4",
              "read address", 32'(mem_addr), exp_map[l]*ROWS + r);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(rsp_valid && rsp_rdata == shadow[l][r], "R2 R6", "read data",
              32'(rsp_rdata), 32'(shadow[l][r]));
    endtask

    task automatic read_all();
        for (int l = 0; l < SEGS; l++)
            for (int r = 0; r < ROWS; r++) do_read(l, r);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        finish_run();
    end

    initial begin
        for (int i = 0; i < SEGS; i++) begin
            exp_map[i] = i;
            exp_cnt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready && !rsp_valid && !mem_en, "R4", "reset state",
              {29'd0, req_ready, rsp_valid, mem_en}, 32'h4);

        // Uniform fill: equal counters, hot equals cold, skip (R7)
        for (int l = 0; l < SEGS; l++)
            for (int r = 0; r < ROWS; r++)
                do_write(l, r, DATA_W'(l*4099 + r*769 + 1), "uniform");
        read_all();

        // Skewed stream: one segment saturates and is swapped out (R3, R6)
        for (int i = 0; i < 12; i++) do_write(1, i % ROWS, DATA_W'(16'h8001 ^ (i*1237)), "skewed");
        for (int i = 0; i < 4; i++)  do_write(2, i, DATA_W'(16'h0F30 + i*3), "skewed");
        read_all();

        // Balanced stream after halving: within threshold (R7, R8)
        for (int i = 0; i < 6; i++) do_write(1, i % ROWS, DATA_W'(16'h5A00 + i*77), "R8");
        do_write(0, 3, 16'hC3C3, "R8");
        for (int i = 0; i < 4; i++) do_write(2, i, DATA_W'(16'h1111 * (i + 1)), "R8");
        for (int i = 0; i < 5; i++) do_write(3, i % ROWS, DATA_W'(16'h7001 + i*513), "R8");
        read_all();

        // Sixteen writes to one segment: only a saturating counter swaps (R3)
        for (int i = 0; i < 16; i++) do_write(3, i % ROWS, DATA_W'(16'hE001 ^ (i*4111)), "saturate");
        read_all();

        finish_run();
    end
endmodule